// File: doc/BRIEF.md
# DRAM Command Legality Guard

This block sits beside a four-bank SDRAM command path. Each clock cycle it is handed the command that a scheduler proposes, the target bank and an auto-precharge flag, and it answers in the same cycle whether that command may be issued. If the command is legal and the cycle is ticked, the block updates its own copy of every bank's state and of the inter-command timers. An illegal command is refused and leaves every piece of tracked state untouched, so the scheduler can try something else in a later cycle.

The block enforces per-bank rules (a row must be open before column access, row-to-column delay, precharge recovery), bus-wide rules (activate-to-activate spacing, a rolling limit of four activates per window, mode-load settling) and burst rules for a 4n-prefetch device, where a running burst may only be cut short by a command of the same direction on a two-clock boundary. All timing limits are given in picoseconds and converted to whole clock cycles by rounding up at the chosen clock period.

Top module: `ddr_cmd_guard`

## Requirements
- R1: A READ (code 2) or WRITE (code 3) to a bank that is not open, an ACTIVATE (code 1) to a bank that is open or still precharging, and a REFRESH (code 6) or LOAD MODE (code 7) while any bank is not idle are refused with violation code 2.
- R2: A READ or WRITE issued fewer than ceil(T_RCD_PS/CLK_PS) ticked cycles after the ACTIVATE of its bank is refused with code 4.
- R3: An ACTIVATE issued fewer than ceil(T_RRD_PS/CLK_PS) ticked cycles after the previous accepted ACTIVATE is refused with code 6.
- R4: An ACTIVATE that would make five accepted ACTIVATEs within any ceil(T_FAW_PS/CLK_PS) consecutive ticked cycles is refused with code 7.
- R5: While a burst runs (fewer than BURST_LEN/2 ticked cycles since the last accepted READ or WRITE), a READ after a READ or a WRITE after a WRITE is accepted only when that count is even; the opposite direction, a PRECHARGE (code 4) to the burst's bank and a PRECHARGE-ALL (code 5) are refused with code 3.
- R6: A READ following an accepted WRITE is refused with code 5 until BURST_LEN/2 + ceil(T_WTR_PS/CLK_PS) ticked cycles have passed since that WRITE.
- R7: A PRECHARGE to an open bank makes it precharging for ceil(T_RP_PS/CLK_PS) ticked cycles; PRECHARGE-ALL does so for every open bank with ceil(T_RPA_PS/CLK_PS) cycles, however many were open; PRECHARGE to a bank that is not open changes nothing.
- R8: After an accepted LOAD MODE, any command other than NOP (code 0) within T_MRD_CK ticked cycles is refused with code 1.
- R9: A READ or WRITE with the auto-precharge flag set moves its bank to precharging for BURST_LEN/2 + ceil(T_RP_PS/CLK_PS) ticked cycles.
- R10: When several rules fail, the reported code is the first of 1, 2, 3, 4, 5, 6, 7 in that order; NOP is always legal; a refused command changes no bank state and no timer.
- R11: With tick_i low no timer advances, no command takes effect, legal_o is 0 and viol_o is 0.
- R12: After reset every bank reads idle and all timing windows are satisfied.
- R13: bank_state_o carries bank b in bits [2b+1:2b] encoded 0 idle, 1 open, 2 precharging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Cycle qualifier; timers advance and commands act only when high |
| cmd_i | input | 3 | Proposed command: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE-ALL, 6 REFRESH, 7 LOAD MODE |
| bank_i | input | 2 | Target bank |
| ap_i | input | 1 | Auto-precharge flag for READ and WRITE |
| legal_o | output | 1 | Command is accepted this cycle |
| viol_o | output | 3 | Violation code, 0 when legal or not ticked |
| bank_state_o | output | 8 | Per-bank state, two bits per bank |

## Verification
The verdict is tried with a long weighted random command stream over all four banks with random auto-precharge and about one cycle in ten unticked, which separates the rule priorities because many commands fail several rules at once. Directed sequences then place commands exactly at the edges of each window: a fifth activate one cycle inside and then just outside the four-activate window, column commands at odd and even burst offsets in both directions, a read one cycle before and at the write-to-read limit, and commands right after a mode load. Unticked cycles during precharge show that the timers freeze rather than merely the verdict.

// File: rtl/ddr_guard_pkg.sv
`timescale 1ns/1ps
package ddr_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_e;

  // Order is priority: lower code wins when several rules fail.
  typedef enum logic [2:0] {
    V_NONE  = 3'd0,
    V_MRD   = 3'd1,
    V_STATE = 3'd2,
    V_BURST = 3'd3,
    V_RCD   = 3'd4,
    V_WTR   = 3'd5,
    V_RRD   = 3'd6,
    V_FAW   = 3'd7
  } viol_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ddr_guard_cdown.sv
`timescale 1ns/1ps
module ddr_guard_cdown #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (tick_i) begin
      if (load_i)           cnt_q <= val_i;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_guard_bank.sv
`timescale 1ns/1ps
module ddr_guard_bank
  import ddr_guard_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RPA = 4,
  parameter int T_AP  = 7
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     act_i,
  input  logic     col_i,
  input  logic     ap_i,
  input  logic     pre_i,
  input  logic     prea_i,
  output bank_st_e state_o,
  output logic     ready_o,
  output logic     open_o,
  output logic     rcd_ok_o
);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  // One counter serves row-to-column delay while open and recovery while precharging.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (act_i) begin
        st_q  <= BK_OPEN;
        cnt_q <= CNT_W'(T_RCD - 1);
      end else if (col_i && ap_i) begin
        st_q  <= BK_PRECH;
        cnt_q <= CNT_W'(T_AP - 1);
      end else if ((pre_i || prea_i) && st_q == BK_OPEN) begin
        st_q  <= BK_PRECH;
        cnt_q <= pre_i ? CNT_W'(T_RP - 1) : CNT_W'(T_RPA - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (st_q == BK_PRECH) begin
        st_q  <= BK_IDLE;
      end
    end
  end

  assign state_o  = (st_q == BK_PRECH && cnt_q == '0) ? BK_IDLE : st_q;
  assign ready_o  = (state_o == BK_IDLE);
  assign open_o   = (st_q == BK_OPEN);
  assign rcd_ok_o = (cnt_q == '0);

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && col_i |-> st_q == BK_OPEN); // R1
  AST_COL_AFTER_RCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && col_i |-> cnt_q == '0); // R2
  AST_ACT_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && act_i |-> st_q != BK_OPEN && cnt_q == '0); // R1
  AST_FROZEN_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && $stable(st_q)); // R11

endmodule

// File: rtl/ddr_guard_faw.sv
`timescale 1ns/1ps
module ddr_guard_faw #(
  parameter int SLOTS = 4,
  parameter int WIN   = 9,
  parameter int W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic act_i,
  output logic ok_o
);

  logic [W-1:0]     cnt_q [SLOTS];
  logic [SLOTS-1:0] free;
  logic [SLOTS-1:0] pick;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (free[s] && !found) begin
        pick[s] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  // Each busy slot holds one activate for the length of the window.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign free[s] = (cnt_q[s] == '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q[s] <= '0;
      else if (tick_i) begin
        if (act_i && pick[s])     cnt_q[s] <= W'(WIN - 1);
        else if (cnt_q[s] != '0)  cnt_q[s] <= cnt_q[s] - 1'b1;
      end
    end
  end

  assign ok_o = |free;

  AST_FAW_SLOT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && act_i |-> |free); // R4

endmodule

// File: rtl/ddr_cmd_guard.sv
`timescale 1ns/1ps
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CLK_PS    = 5000,
  parameter int T_RCD_PS  = 12500,
  parameter int T_RRD_PS  = 7500,
  parameter int T_FAW_PS  = 45000,
  parameter int T_RP_PS   = 12500,
  parameter int T_RPA_PS  = 17500,
  parameter int T_WTR_PS  = 7500,
  parameter int T_MRD_CK  = 2,
  parameter int BURST_LEN = 8,
  parameter int FAW_ACTS  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [2:0]             cmd_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic                   ap_i,
  output logic                   legal_o,
  output logic [2:0]             viol_o,
  output logic [2*NUM_BANKS-1:0] bank_state_o
);

  localparam int RCD_C    = ceil_div(T_RCD_PS, CLK_PS);
  localparam int RRD_C    = ceil_div(T_RRD_PS, CLK_PS);
  localparam int FAW_C    = ceil_div(T_FAW_PS, CLK_PS);
  localparam int RP_C     = ceil_div(T_RP_PS, CLK_PS);
  localparam int RPA_C    = ceil_div(T_RPA_PS, CLK_PS);
  localparam int WTR_C    = ceil_div(T_WTR_PS, CLK_PS);
  localparam int BL_CYC   = BURST_LEN / 2;
  localparam int AP_C     = BL_CYC + RP_C;
  localparam int AGE_MAX  = BL_CYC + WTR_C;
  localparam int AGE_W    = $clog2(AGE_MAX + 1);
  localparam int BK_W     = $clog2(max3(RCD_C, RPA_C, AP_C) + 1);
  localparam int FAW_W    = $clog2(FAW_C + 1);
  localparam int TM_W     = $clog2(max3(RRD_C, T_MRD_CK, 1) + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);
  localparam logic [AGE_W-1:0] AGE_BL  = AGE_W'(BL_CYC);

  cmd_e  cmd;
  viol_e code;
  logic  go, is_col, state_bad, burst_bad, in_burst;
  logic  rrd_ok, mrd_ok, faw_ok;

  logic [NUM_BANKS-1:0] bk_ready, bk_open, bk_rcd_ok;
  logic [NUM_BANKS-1:0] bk_act, bk_col, bk_pre;
  bank_st_e             bk_state [NUM_BANKS];

  logic [AGE_W-1:0]  col_age_q;
  logic              col_wr_q;
  logic [BANK_W-1:0] col_bank_q;

  assign cmd      = cmd_e'(cmd_i);
  assign is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign in_burst = (col_age_q < AGE_BL);

  always_comb begin
    unique case (cmd)
      CMD_ACT:          state_bad = !bk_ready[bank_i];
      CMD_RD, CMD_WR:   state_bad = !bk_open[bank_i];
      CMD_REF, CMD_MRS: state_bad = !(&bk_ready);
      default:          state_bad = 1'b0;
    endcase
  end

  // 4n prefetch: same-direction interruption only on even burst offsets (two clocks).
  always_comb begin
    burst_bad = 1'b0;
    if (in_burst) begin
      unique case (cmd)
        CMD_RD:   burst_bad = col_wr_q || col_age_q[0];
        CMD_WR:   burst_bad = !col_wr_q || col_age_q[0];
        CMD_PRE:  burst_bad = (bank_i == col_bank_q);
        CMD_PREA: burst_bad = 1'b1;
        default:  burst_bad = 1'b0;
      endcase
    end
  end

  always_comb begin
    code = V_NONE;
    if (cmd != CMD_NOP) begin
      if (!mrd_ok)                                           code = V_MRD;
      else if (state_bad)                                    code = V_STATE;
      else if (burst_bad)                                    code = V_BURST;
      else if (is_col && !bk_rcd_ok[bank_i])                 code = V_RCD;
      else if (cmd == CMD_RD && col_wr_q && col_age_q < AGE_TOP) code = V_WTR;
      else if (cmd == CMD_ACT && !rrd_ok)                    code = V_RRD;
      else if (cmd == CMD_ACT && !faw_ok)                    code = V_FAW;
    end
  end

  assign go      = tick_i && (code == V_NONE);
  assign legal_o = go;
  assign viol_o  = tick_i ? 3'(code) : 3'd0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bk_act[b] = go && (cmd == CMD_ACT) && (bank_i == BANK_W'(b));
    assign bk_col[b] = go && is_col && (bank_i == BANK_W'(b));
    assign bk_pre[b] = go && (cmd == CMD_PRE) && (bank_i == BANK_W'(b));

    ddr_guard_bank #(
      .CNT_W (BK_W),
      .T_RCD (RCD_C),
      .T_RP  (RP_C),
      .T_RPA (RPA_C),
      .T_AP  (AP_C)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .act_i    (bk_act[b]),
      .col_i    (bk_col[b]),
      .ap_i     (ap_i),
      .pre_i    (bk_pre[b]),
      .prea_i   (go && cmd == CMD_PREA),
      .state_o  (bk_state[b]),
      .ready_o  (bk_ready[b]),
      .open_o   (bk_open[b]),
      .rcd_ok_o (bk_rcd_ok[b])
    );

    assign bank_state_o[2*b +: 2] = bk_state[b];
  end

  ddr_guard_cdown #(.W(TM_W)) u_rrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (go && cmd == CMD_ACT),
    .val_i  (TM_W'(RRD_C - 1)),
    .zero_o (rrd_ok)
  );

  ddr_guard_cdown #(.W(TM_W)) u_mrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (go && cmd == CMD_MRS),
    .val_i  (TM_W'(T_MRD_CK - 1)),
    .zero_o (mrd_ok)
  );

  ddr_guard_faw #(
    .SLOTS (FAW_ACTS),
    .WIN   (FAW_C),
    .W     (FAW_W)
  ) u_faw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .act_i  (go && cmd == CMD_ACT),
    .ok_o   (faw_ok)
  );

  // Age of the last accepted column command, saturating past the write-to-read limit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_age_q  <= AGE_TOP;
      col_wr_q   <= 1'b0;
      col_bank_q <= '0;
    end else if (tick_i) begin
      if (go && is_col) begin
        col_age_q  <= AGE_W'(1);
        col_wr_q   <= (cmd == CMD_WR);
        col_bank_q <= bank_i;
      end else if (col_age_q != AGE_TOP) begin
        col_age_q  <= col_age_q + 1'b1;
      end
    end
  end

  AST_COL_ON_OPEN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_o && is_col |-> bank_state_o[2*bank_i +: 2] == 2'(BK_OPEN)); // R1
  AST_BURST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_o && is_col && in_burst |-> !col_age_q[0]); // R5
  AST_MRD_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_o && cmd == CMD_MRS |=> (T_MRD_CK == 1) || !legal_o || cmd == CMD_NOP); // R8
  AST_REF_MRS_ALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_o && (cmd == CMD_REF || cmd == CMD_MRS) |-> bank_state_o == '0); // R1
  AST_NO_VERDICT_UNTICKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !legal_o && viol_o == 3'd0); // R11

endmodule

// File: tb/ddr_cmd_guard_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_guard_tb_top;

  localparam int CLK_PS = 5000;
  localparam int RCD = (12500 + CLK_PS - 1) / CLK_PS;
  localparam int RRD = (7500  + CLK_PS - 1) / CLK_PS;
  localparam int FAW = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int RP  = (12500 + CLK_PS - 1) / CLK_PS;
  localparam int RPA = (17500 + CLK_PS - 1) / CLK_PS;
  localparam int WTR = (7500  + CLK_PS - 1) / CLK_PS;
  localparam int MRD = 2;
  localparam int BLC = 4;

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, REF = 6, MRS = 7;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] bank_i = 2'd0;
  logic       ap_i = 1'b0;
  logic       legal_o;
  logic [2:0] viol_o;
  logic [7:0] bank_state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_guard dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .cmd_i        (cmd_i),
    .bank_i       (bank_i),
    .ap_i         (ap_i),
    .legal_o      (legal_o),
    .viol_o       (viol_o),
    .bank_state_o (bank_state_o)
  );

  // Timestamp model: everything measured in ticked cycles.
  int now;
  bit m_open [4];
  int m_ready [4];
  int m_act_t [4];
  int m_faw [4];
  int m_last_act, m_col_t, m_col_bank, m_mrd_t;
  bit m_col_wr;

  task automatic model_reset();
    now = 0;
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; m_ready[k] = -1000; m_act_t[k] = -1000; m_faw[k] = -1000;
    end
    m_last_act = -1000; m_col_t = -1000; m_col_bank = 0; m_mrd_t = -1000; m_col_wr = 0;
  endtask

  function automatic int model_code(input int c, input int b);
    int age;
    bit all_idle;
    age = now - m_col_t;
    all_idle = 1;
    for (int k = 0; k < 4; k++) if (m_open[k] || now < m_ready[k]) all_idle = 0;
    if (c == NOP) return 0;
    if (now - m_mrd_t < MRD) return 1;
    if (c == ACT && (m_open[b] || now < m_ready[b])) return 2;
    if ((c == RD || c == WR) && !m_open[b]) return 2;
    if ((c == REF || c == MRS) && !all_idle) return 2;
    if (age < BLC) begin
      if (c == RD && (m_col_wr || (age % 2) != 0)) return 3;
      if (c == WR && (!m_col_wr || (age % 2) != 0)) return 3;
      if (c == PRE && b == m_col_bank) return 3;
      if (c == PREA) return 3;
    end
    if ((c == RD || c == WR) && now - m_act_t[b] < RCD) return 4;
    if (c == RD && m_col_wr && age < BLC + WTR) return 5;
    if (c == ACT && now - m_last_act < RRD) return 6;
    if (c == ACT && now - m_faw[0] < FAW) return 7;
    return 0;
  endfunction

  function automatic logic [7:0] model_states();
    logic [7:0] s;
    for (int k = 0; k < 4; k++) begin
      if (m_open[k])            s[2*k +: 2] = 2'd1;
      else if (now < m_ready[k]) s[2*k +: 2] = 2'd2;
      else                       s[2*k +: 2] = 2'd0;
    end
    return s;
  endfunction

  task automatic model_apply(input int c, input int b, input bit ap);
    case (c)
      ACT: begin
        m_open[b] = 1; m_act_t[b] = now; m_last_act = now;
        m_faw[0] = m_faw[1]; m_faw[1] = m_faw[2]; m_faw[2] = m_faw[3]; m_faw[3] = now;
      end
      RD, WR: begin
        m_col_t = now; m_col_wr = (c == WR); m_col_bank = b;
        if (ap) begin m_open[b] = 0; m_ready[b] = now + BLC + RP; end
      end
      PRE: if (m_open[b]) begin m_open[b] = 0; m_ready[b] = now + RP; end
      PREA: for (int k = 0; k < 4; k++)
              if (m_open[k]) begin m_open[k] = 0; m_ready[k] = now + RPA; end
      MRS: m_mrd_t = now;
      default: ;
    endcase
  endtask

  function automatic string req_of(input int code);
    case (code)
      1: return "R8";
      2: return "R1";
      3: return "R5";
      4: return "R2";
      5: return "R6";
      6: return "R3";
      7: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, now);
    end
  endtask

  task automatic step(input int c, input int b, input bit ap, input bit tk);
    int code;
    logic [7:0] st;
    @(negedge clk);
    cmd_i = 3'(c); bank_i = 2'(b); ap_i = ap; tick_i = tk;
    #1;
    code = model_code(c, b);
    st   = model_states();
    if (tk) begin
      check(req_of(code), int'(viol_o), code, "viol_o");
      check(req_of(code), int'(legal_o), (code == 0) ? 1 : 0, "legal_o");
    end else begin
      check("R11", int'(legal_o), 0, "legal_o unticked");
      check("R11", int'(viol_o), 0, "viol_o unticked");
    end
    check("R13", int'(bank_state_o), int'(st), "bank_state_o"); // also R7, R9
    @(posedge clk);
    if (tk && code == 0) model_apply(c, b, ap);
    if (tk) now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #12;
    // R12: reset state, NOP accepted while held
    check("R12", int'(bank_state_o), 0, "bank_state_o in reset");
    check("R12", int'(legal_o), 1, "legal_o in reset");
    check("R12", int'(viol_o), 0, "viol_o in reset");
    @(negedge clk);
    rst_ni = 1'b1;

    // R3/R4: activate spacing and the four-activate window
    step(ACT, 0, 0, 1);   // t0
    step(ACT, 1, 0, 1);   // t1 too close (R3)
    step(ACT, 1, 0, 1);   // t2
    step(PRE, 0, 0, 1);   // t3
    step(ACT, 2, 0, 1);   // t4
    step(PRE, 1, 0, 1);   // t5
    step(ACT, 0, 0, 1);   // t6 fourth in window
    idle(1);
    step(ACT, 1, 0, 1);   // t8 fifth inside window (R4)
    step(ACT, 1, 0, 1);   // t9 window clear
    // R2: row-to-column delay
    step(RD, 1, 0, 1);    // t10
    idle(2);
    step(RD, 1, 0, 1);    // t13
    // R5: burst interruption
    step(RD, 1, 0, 1);    // odd offset
    step(RD, 1, 0, 1);    // even offset, new burst at t15
    step(WR, 1, 0, 1);    // opposite direction
    idle(2);
    step(WR, 2, 0, 1);    // t19 burst ended
    step(RD, 2, 0, 1);    // read into write burst
    idle(3);
    // R6: write-to-read
    step(RD, 2, 0, 1);    // one short of the limit
    step(RD, 2, 0, 1);    // at the limit
    step(PRE, 2, 0, 1);   // precharge of burst bank (R5)
    step(PREA, 0, 0, 1);  // precharge-all inside burst (R5)
    idle(3);
    // R7: precharge-all recovery on every open bank
    step(PREA, 0, 0, 1);
    step(ACT, 0, 0, 1);   // still precharging (R1)
    // R11: unticked cycles freeze the recovery timers
    step(NOP, 0, 0, 0);
    step(ACT, 0, 0, 0);
    step(NOP, 0, 0, 0);
    step(MRS, 0, 0, 1);   // banks not idle (R1)
    idle(3);
    // R8: mode-load settling
    step(MRS, 0, 0, 1);
    step(ACT, 0, 0, 1);
    step(ACT, 0, 0, 1);
    idle(3);
    // R9: auto-precharge after a read
    step(RD, 0, 1, 1);
    step(RD, 0, 0, 1);
    step(REF, 0, 0, 1);
    idle(BLC + RP);
    step(REF, 0, 0, 1);
    step(PRE, 3, 0, 1);   // R7: precharge to a closed bank has no effect
    idle(2);

    // Weighted random stream (R10 priority under mixed failures)
    for (int i = 0; i < 6000; i++) begin
      int r, c;
      r = int'($urandom % 100);
      if      (r < 24) c = ACT;
      else if (r < 44) c = RD;
      else if (r < 60) c = WR;
      else if (r < 74) c = PRE;
      else if (r < 78) c = PREA;
      else if (r < 82) c = REF;
      else if (r < 84) c = MRS;
      else             c = NOP;
      step(c, int'($urandom % 4), ($urandom % 4) == 0, ($urandom % 10) != 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule